// File: doc/BRIEF.md
# Segmented Ring Transfer Arbiter

This block is the central arbiter and beat-level datapath for an on-chip interconnect. Twelve units sit at positions 0 to 11 around four one-way rings. Rings 0 and 2 carry data forward, towards higher position numbers and wrapping from 11 to 0. Rings 1 and 3 carry data in reverse. A unit holds a request that names a destination and a length in beats. The arbiter chooses a ring and books every hop between source and destination on that ring. It grants the request only when all of those hops are unbooked. Transfers on one ring that do not overlap run side by side, up to three per ring.

The rings run at half the core rate, so each active transfer moves one 128-bit beat every second core cycle. While a beat is on the ring, the source sees a beat strobe and presents its data on `tx_data`. The destination sees the same data on `rx_data` with `rx_valid`. The hops a transfer booked are released as its last beat completes. Requests are served round-robin across the twelve ports, one grant per cycle. Malformed requests are flagged and are never granted.

Top module: `ring_xfer_arbiter`

## Requirements
- R1: A request whose destination equals its own port, whose destination is 12 or above, or whose length is 0 raises `req_err` for that port in the cycle after each cycle it is presented, and is never granted.
- R2: After reset `grant`, `req_err`, `tx_beat` and `rx_valid` are all zero. At most one `grant` bit is high per cycle. A grant to an otherwise idle system appears one cycle after the request is first presented, and `grant_ring` carries the index of the chosen ring in that cycle.
- R3: The preferred direction is the one with the fewer hops: forward distance f = (dst - src) mod 12, reverse distance 12 - f, with a tie going forward. The lower-indexed ring of that direction is tried first, then the other ring of the same direction, then the opposite direction in index order.
- R4: On a forward ring a transfer books hops src, src+1 … dst-1, where hop k links position k to k+1. On a reverse ring it books hops src, src-1 … dst+1, where hop k links position k to k-1. A ring is chosen only if none of those hops is booked on it, and transfers with disjoint hops may share a ring.
- R5: No ring carries more than three active transfers. When a ring is full, a request moves on to the next ring in its preference order.
- R6: A transfer of L beats granted in cycle G drives `tx_beat[src]` and `rx_valid[dst]` high in cycles G+1, G+3 … G+2L-1 and low in between. In each of those cycles `rx_data` of the destination equals `tx_data` of the source.
- R7: The booked hops and the source and destination are released as the last beat completes. A request waiting only on those resources is granted in cycle G+2L+1.
- R8: Round-robin order: after a grant to port p, the search for the next winner starts at port (p+1) mod 12.
- R9: A port is source of at most one transfer and destination of at most one transfer at a time. A request whose source or destination is busy waits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 12 | Request held by each port |
| req_dst | input | 48 | Destination per port, 4 bits each |
| req_len | input | 48 | Length in beats per port, 4 bits each |
| tx_data | input | 1536 | Beat data per source port, 128 bits each |
| grant | output | 12 | One-cycle grant pulse, one-hot or zero |
| grant_ring | output | 2 | Ring chosen for the grant shown this cycle |
| req_err | output | 12 | Malformed-request flag per port |
| tx_beat | output | 12 | Source beat strobe per port |
| rx_valid | output | 12 | Destination beat strobe per port |
| rx_data | output | 1536 | Beat data per destination port, 128 bits each |

## Verification
A booking mask that is left stale after a transfer finishes shows up as a missing or late grant. The hop-blocking and release checks catch it within a few cycles of the expected grant cycle. A wrong ring preference or slot count shows at `grant_ring` in the same cycle as the grant, so every source and destination pair is swept on an idle system and on rings that are deliberately full. Beat pacing faults show at `tx_beat`, `rx_valid` and `rx_data` one or two cycles after the grant.

// File: rtl/ringarb_pkg.sv
package ringarb_pkg;
   typedef enum logic {DIR_FWD = 1'b0, DIR_REV = 1'b1} ring_dir_e;

   // even ring index carries data forward, odd index in reverse
   function automatic ring_dir_e ring_dir(input int r);
      return (r % 2 == 0) ? DIR_FWD : DIR_REV;
   endfunction
endpackage

// File: rtl/ringarb_route.sv
module ringarb_route
   import ringarb_pkg::*;
#(
   parameter int N_UNITS = 12,
   parameter int N_RINGS = 4,
   parameter int LEN_W   = 4,
   parameter int PORT    = 0,
   localparam int ID_W   = $clog2(N_UNITS),
   localparam int RING_W = $clog2(N_RINGS)
)(
   input  logic                       req_valid,
   input  logic [ID_W-1:0]            req_dst,
   input  logic [LEN_W-1:0]           req_len,
   input  logic [N_RINGS*N_UNITS-1:0] hop_busy,
   input  logic [N_RINGS-1:0]         ring_room,
   input  logic [N_UNITS-1:0]         src_busy,
   input  logic [N_UNITS-1:0]         dst_busy,
   output logic                       ok,
   output logic [RING_W-1:0]          ring,
   output logic [N_UNITS-1:0]         mask,
   output logic                       bad
);
   int                 fwd;
   logic [N_UNITS-1:0] fmask, rmask, cand;
   ring_dir_e          pref, want;
   logic               found;

   always_comb begin
      bad  = req_valid && (int'(req_dst) >= N_UNITS || int'(req_dst) == PORT || req_len == '0);
      fwd  = (int'(req_dst) + N_UNITS - PORT) % N_UNITS;
      for (int k = 0; k < N_UNITS; k++) begin
         fmask[k] = ((k + N_UNITS - PORT) % N_UNITS) < fwd;
         rmask[k] = ((PORT + N_UNITS - k) % N_UNITS) < (N_UNITS - fwd);
      end
      pref  = (fwd <= N_UNITS - fwd) ? DIR_FWD : DIR_REV;
      found = 1'b0;
      ring  = '0;
      mask  = '0;
      for (int pass = 0; pass < 2; pass++) begin
         want = (pass == 0) ? pref : ((pref == DIR_FWD) ? DIR_REV : DIR_FWD);
         for (int r = 0; r < N_RINGS; r++) begin
            cand = (ring_dir(r) == DIR_FWD) ? fmask : rmask;
            if (!found && ring_dir(r) == want && ring_room[r] &&
                (hop_busy[r*N_UNITS +: N_UNITS] & cand) == '0) begin
               found = 1'b1;
               ring  = RING_W'(r);
               mask  = cand;
            end
         end
      end
      ok = req_valid && !bad && !src_busy[PORT] && !dst_busy[req_dst] && found;
   end
endmodule

// File: rtl/ringarb_rr.sv
module ringarb_rr #(
   parameter int N_UNITS = 12,
   localparam int ID_W   = $clog2(N_UNITS)
)(
   input  logic               clk,
   input  logic               rst_n,
   input  logic [N_UNITS-1:0] elig,
   output logic               win_valid,
   output logic [ID_W-1:0]    win_idx
);
   logic [ID_W-1:0] ptr;

   always_comb begin
      win_valid = 1'b0;
      win_idx   = '0;
      for (int i = 0; i < N_UNITS; i++) begin
         if (!win_valid && elig[(int'(ptr) + i) % N_UNITS]) begin
            win_valid = 1'b1;
            win_idx   = ID_W'((int'(ptr) + i) % N_UNITS);
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         ptr <= '0;
      else if (win_valid) ptr <= (int'(win_idx) == N_UNITS-1) ? '0 : win_idx + 1'b1;
   end

   AST_RR_PTR_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      int'(ptr) < N_UNITS); // R8
endmodule

// File: rtl/ringarb_lane.sv
module ringarb_lane #(
   parameter int N_UNITS = 12,
   parameter int SLOTS   = 3,
   parameter int LEN_W   = 4,
   localparam int ID_W   = $clog2(N_UNITS),
   localparam int SLOT_W = (SLOTS > 1) ? $clog2(SLOTS) : 1
)(
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    load,
   input  logic [ID_W-1:0]         load_src,
   input  logic [ID_W-1:0]         load_dst,
   input  logic [LEN_W-1:0]        load_len,
   input  logic [N_UNITS-1:0]      load_mask,
   output logic [N_UNITS-1:0]      hop_busy,
   output logic                    room,
   output logic [N_UNITS-1:0]      src_busy,
   output logic [N_UNITS-1:0]      dst_busy,
   output logic [SLOTS-1:0]        beat,
   output logic [SLOTS*ID_W-1:0]   slot_src,
   output logic [SLOTS*ID_W-1:0]   slot_dst
);
   logic               act   [SLOTS];
   logic               phase [SLOTS];
   logic [LEN_W-1:0]   rem   [SLOTS];
   logic [ID_W-1:0]    s_src [SLOTS];
   logic [ID_W-1:0]    s_dst [SLOTS];
   logic [N_UNITS-1:0] s_mask[SLOTS];
   logic [SLOT_W-1:0]  free_idx;

   always_comb begin
      room     = 1'b0;
      free_idx = '0;
      hop_busy = '0;
      src_busy = '0;
      dst_busy = '0;
      for (int s = 0; s < SLOTS; s++) begin
         if (!room && !act[s]) begin
            room     = 1'b1;
            free_idx = SLOT_W'(s);
         end
         if (act[s]) begin
            hop_busy           = hop_busy | s_mask[s];
            src_busy[s_src[s]] = 1'b1;
            dst_busy[s_dst[s]] = 1'b1;
         end
      end
   end

   for (genvar s = 0; s < SLOTS; s++) begin : g_slot
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            act[s]    <= 1'b0;
            phase[s]  <= 1'b0;
            rem[s]    <= '0;
            s_src[s]  <= '0;
            s_dst[s]  <= '0;
            s_mask[s] <= '0;
         end else if (load && free_idx == SLOT_W'(s) && !act[s]) begin
            act[s]    <= 1'b1;
            phase[s]  <= 1'b0;
            rem[s]    <= load_len;
            s_src[s]  <= load_src;
            s_dst[s]  <= load_dst;
            s_mask[s] <= load_mask;
         end else if (act[s]) begin
            phase[s] <= ~phase[s];
            if (phase[s]) begin
               rem[s] <= rem[s] - 1'b1;
               if (rem[s] == 1) act[s] <= 1'b0;
            end
         end
      end
      assign beat[s]                    = act[s] & phase[s];
      assign slot_src[s*ID_W +: ID_W]   = s_src[s];
      assign slot_dst[s*ID_W +: ID_W]   = s_dst[s];

      AST_BEAT_GAP: assert property (@(posedge clk) disable iff (!rst_n)
         beat[s] |=> !beat[s]); // R6
   end

   AST_NO_HOP_CLASH: assert property (@(posedge clk) disable iff (!rst_n)
      load |-> (load_mask & hop_busy) == '0); // R4
   AST_SLOT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
      load |-> room); // R5
endmodule

// File: rtl/ring_xfer_arbiter.sv
module ring_xfer_arbiter #(
   parameter int N_UNITS = 12,
   parameter int N_RINGS = 4,
   parameter int SLOTS   = 3,
   parameter int LEN_W   = 4,
   parameter int DATA_W  = 128,
   localparam int ID_W   = $clog2(N_UNITS),
   localparam int RING_W = $clog2(N_RINGS)
)(
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic [N_UNITS-1:0]        req_valid,
   input  logic [N_UNITS*ID_W-1:0]   req_dst,
   input  logic [N_UNITS*LEN_W-1:0]  req_len,
   input  logic [N_UNITS*DATA_W-1:0] tx_data,
   output logic [N_UNITS-1:0]        grant,
   output logic [RING_W-1:0]         grant_ring,
   output logic [N_UNITS-1:0]        req_err,
   output logic [N_UNITS-1:0]        tx_beat,
   output logic [N_UNITS-1:0]        rx_valid,
   output logic [N_UNITS*DATA_W-1:0] rx_data
);
   localparam int N_SLOTS = N_RINGS * SLOTS;

   if (N_RINGS < 2 || N_RINGS % 2 != 0) begin : g_bad_rings
      $error("ring count must be even and at least two");
   end
   if (SLOTS < 1 || N_UNITS < 3) begin : g_bad_sizes
      $error("need at least one slot per ring and three units");
   end

   logic [N_RINGS*N_UNITS-1:0] hop_busy, lane_src_busy, lane_dst_busy;
   logic [N_RINGS-1:0]         room;
   logic [N_UNITS-1:0]         src_busy, dst_busy, elig, bad;
   logic [RING_W-1:0]          rt_ring [N_UNITS];
   logic [N_UNITS-1:0]         rt_mask [N_UNITS];
   logic [N_SLOTS-1:0]         lane_beat;
   logic [N_SLOTS*ID_W-1:0]    lane_src, lane_dst;
   logic                       win_valid;
   logic [ID_W-1:0]            win_idx, win_dst;
   logic [LEN_W-1:0]           win_len;
   logic [RING_W-1:0]          win_ring;
   logic [N_UNITS-1:0]         win_mask;

   for (genvar p = 0; p < N_UNITS; p++) begin : g_port
      ringarb_route #(.N_UNITS(N_UNITS), .N_RINGS(N_RINGS), .LEN_W(LEN_W), .PORT(p)) u_route (
         .req_valid (req_valid[p]),
         .req_dst   (req_dst[p*ID_W +: ID_W]),
         .req_len   (req_len[p*LEN_W +: LEN_W]),
         .hop_busy  (hop_busy),
         .ring_room (room),
         .src_busy  (src_busy),
         .dst_busy  (dst_busy),
         .ok        (elig[p]),
         .ring      (rt_ring[p]),
         .mask      (rt_mask[p]),
         .bad       (bad[p])
      );
   end

   ringarb_rr #(.N_UNITS(N_UNITS)) u_rr (
      .clk, .rst_n, .elig, .win_valid, .win_idx
   );

   assign win_ring = rt_ring[win_idx];
   assign win_mask = rt_mask[win_idx];
   assign win_dst  = req_dst[win_idx*ID_W +: ID_W];
   assign win_len  = req_len[win_idx*LEN_W +: LEN_W];

   for (genvar r = 0; r < N_RINGS; r++) begin : g_lane
      ringarb_lane #(.N_UNITS(N_UNITS), .SLOTS(SLOTS), .LEN_W(LEN_W)) u_lane (
         .clk       (clk),
         .rst_n     (rst_n),
         .load      (win_valid && win_ring == RING_W'(r)),
         .load_src  (win_idx),
         .load_dst  (win_dst),
         .load_len  (win_len),
         .load_mask (win_mask),
         .hop_busy  (hop_busy[r*N_UNITS +: N_UNITS]),
         .room      (room[r]),
         .src_busy  (lane_src_busy[r*N_UNITS +: N_UNITS]),
         .dst_busy  (lane_dst_busy[r*N_UNITS +: N_UNITS]),
         .beat      (lane_beat[r*SLOTS +: SLOTS]),
         .slot_src  (lane_src[r*SLOTS*ID_W +: SLOTS*ID_W]),
         .slot_dst  (lane_dst[r*SLOTS*ID_W +: SLOTS*ID_W])
      );
   end

   always_comb begin
      src_busy = '0;
      dst_busy = '0;
      for (int r = 0; r < N_RINGS; r++) begin
         src_busy = src_busy | lane_src_busy[r*N_UNITS +: N_UNITS];
         dst_busy = dst_busy | lane_dst_busy[r*N_UNITS +: N_UNITS];
      end
   end

   // beat datapath: each active slot steers its source's word to its destination
   always_comb begin
      tx_beat  = '0;
      rx_valid = '0;
      rx_data  = '0;
      for (int k = 0; k < N_SLOTS; k++) begin
         if (lane_beat[k]) begin
            tx_beat[lane_src[k*ID_W +: ID_W]]  = 1'b1;
            rx_valid[lane_dst[k*ID_W +: ID_W]] = 1'b1;
            rx_data[int'(lane_dst[k*ID_W +: ID_W])*DATA_W +: DATA_W] =
               tx_data[int'(lane_src[k*ID_W +: ID_W])*DATA_W +: DATA_W];
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         grant      <= '0;
         grant_ring <= '0;
         req_err    <= '0;
      end else begin
         grant      <= win_valid ? (N_UNITS'(1) << win_idx) : '0;
         grant_ring <= win_valid ? win_ring : grant_ring;
         req_err    <= bad;
      end
   end

   AST_ONE_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(grant)); // R2
   AST_ERR_NOT_GRANTED: assert property (@(posedge clk) disable iff (!rst_n)
      (grant & req_err) == '0); // R1
   AST_GRANT_HAD_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      (grant & ~$past(req_valid)) == '0); // R2
   AST_ONE_PER_END: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(rx_valid) == $countones(tx_beat)); // R9
endmodule

// File: tb/ring_xfer_arbiter_bench.sv
`timescale 1ns/1ps
module ring_xfer_arbiter_bench;
   localparam int N  = 12;
   localparam int LW = 4;
   localparam int DW = 128;
   localparam int IW = 4;
   localparam int RW = 2;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic [N-1:0]      req_valid = '0;
   logic [N*IW-1:0]   req_dst = '0;
   logic [N*LW-1:0]   req_len = '0;
   logic [N*DW-1:0]   tx_data;
   logic [N-1:0]      grant, req_err, tx_beat, rx_valid;
   logic [RW-1:0]     grant_ring;
   logic [N*DW-1:0]   rx_data;

   int errors = 0;
   int checks = 0;
   bit done   = 0;

   always #2.5 clk = ~clk;

   ring_xfer_arbiter u_ring_xfer_arbiter (
      .clk, .rst_n, .req_valid, .req_dst, .req_len, .tx_data,
      .grant, .grant_ring, .req_err, .tx_beat, .rx_valid, .rx_data
   );

   function automatic logic [DW-1:0] pattern(input int u);
      return {4{32'hC0DE0000 + 32'(u)}};
   endfunction

   function automatic int pref_ring(input int s, input int d);
      int f = (d - s + N) % N;
      return (f <= N - f) ? 0 : 1;
   endfunction

   task automatic check_eq(input string req, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   task automatic set_req(input int p, input int d, input int l);
      req_valid[p]           = 1'b1;
      req_dst[p*IW +: IW]    = IW'(d);
      req_len[p*LW +: LW]    = LW'(l);
   endtask

   task automatic wait_grant(input int p, output int cyc);
      cyc = 0;
      do begin
         @(negedge clk);
         cyc++;
      end while (!grant[p] && cyc < 100);
   endtask

   task automatic report();
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL R2 watchdog: actual=timeout expected=finish");
         report();
      end
   end

   initial begin
      int cyc, g0, g5, nb;
      for (int u = 0; u < N; u++) tx_data[u*DW +: DW] = pattern(u);
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R2: reset state
      check_eq("R2", "grant after reset", int'(grant), 0);
      check_eq("R2", "req_err after reset", int'(req_err), 0);
      check_eq("R2", "tx_beat after reset", int'(tx_beat), 0);
      check_eq("R2", "rx_valid after reset", int'(rx_valid), 0);

      // R1: self-addressed, out-of-range and zero-length requests
      for (int p = 0; p < N; p++) begin
         set_req(p, p, 1);
         @(negedge clk);
         check_eq("R1", $sformatf("self err port %0d", p), int'(req_err[p]), 1);
         check_eq("R1", "no grant for self request", int'(grant), 0);
         req_valid[p] = 1'b0;
         @(negedge clk);
         check_eq("R1", "err cleared", int'(req_err), 0);
      end
      set_req(3, 12, 2);
      set_req(5, 6, 0);
      repeat (3) @(negedge clk);
      check_eq("R1", "range and zero length err", int'(req_err), (1 << 3) | (1 << 5));
      check_eq("R1", "no grant for bad requests", int'(grant), 0);
      req_valid = '0;
      repeat (2) @(negedge clk);

      // R3/R6: every source and destination pair on an idle system
      for (int s = 0; s < N; s++) begin
         for (int d = 0; d < N; d++) begin
            if (d == s) continue;
            set_req(s, d, 1);
            wait_grant(s, cyc);
            check_eq("R2", $sformatf("grant latency %0d->%0d", s, d), cyc, 1);
            check_eq("R3", $sformatf("ring %0d->%0d", s, d), int'(grant_ring), pref_ring(s, d));
            req_valid[s] = 1'b0;
            @(negedge clk);
            check_eq("R6", "rx_valid on beat", int'(rx_valid), 1 << d);
            check_eq("R6", "tx_beat on beat", int'(tx_beat), 1 << s);
            checks++;
            if (rx_data[d*DW +: DW] !== pattern(s)) begin
               errors++;
               $display("FAIL R6 rx_data %0d->%0d: actual=%h expected=%h", s, d,
                        rx_data[d*DW +: 32], pattern(s)[31:0]);
            end
            @(negedge clk);
            check_eq("R6", "no beat in gap cycle", int'(tx_beat | rx_valid), 0);
         end
      end
      repeat (4) @(negedge clk);

      // R4: hop booking forces the reverse ring; disjoint hops share a ring
      set_req(0, 6, 15); wait_grant(0, cyc); req_valid[0] = 1'b0;
      check_eq("R4", "0->6 ring", int'(grant_ring), 0);
      set_req(1, 7, 15); wait_grant(1, cyc); req_valid[1] = 1'b0;
      check_eq("R4", "1->7 ring", int'(grant_ring), 2);
      set_req(2, 4, 15); wait_grant(2, cyc); req_valid[2] = 1'b0;
      check_eq("R4", "2->4 blocked forward", int'(grant_ring), 1);
      set_req(8, 10, 15); wait_grant(8, cyc); req_valid[8] = 1'b0;
      check_eq("R4", "8->10 shares ring 0", int'(grant_ring), 0);
      repeat (40) @(negedge clk);

      // R5: three transfers fill a ring, then fallback order
      set_req(0, 3, 15);  wait_grant(0, cyc);  req_valid[0] = 1'b0;
      check_eq("R5", "a ring", int'(grant_ring), 0);
      set_req(1, 2, 15);  wait_grant(1, cyc);  req_valid[1] = 1'b0;
      check_eq("R4", "b ring", int'(grant_ring), 2);
      set_req(4, 5, 15);  wait_grant(4, cyc);  req_valid[4] = 1'b0;
      check_eq("R4", "c ring", int'(grant_ring), 0);
      set_req(7, 8, 15);  wait_grant(7, cyc);  req_valid[7] = 1'b0;
      check_eq("R5", "d ring third slot", int'(grant_ring), 0);
      set_req(9, 10, 15); wait_grant(9, cyc);  req_valid[9] = 1'b0;
      check_eq("R5", "e ring 0 full", int'(grant_ring), 2);
      set_req(11, 0, 15); wait_grant(11, cyc); req_valid[11] = 1'b0;
      check_eq("R5", "f ring", int'(grant_ring), 2);
      set_req(6, 11, 15); wait_grant(6, cyc);  req_valid[6] = 1'b0;
      check_eq("R3", "g both forward full", int'(grant_ring), 1);
      repeat (40) @(negedge clk);

      // R7/R9/R8: release timing with busy source and busy destination
      set_req(0, 3, 3); wait_grant(0, cyc); req_valid[0] = 1'b0;
      set_req(0, 5, 1);
      set_req(5, 3, 1);
      g0 = 0; g5 = 0; nb = 0;
      for (int c = 1; c <= 12; c++) begin
         @(negedge clk);
         if (c <= 6 && tx_beat[0] && rx_valid[3]) nb++;
         if (grant[5]) begin g5 = c; req_valid[5] = 1'b0; end
         if (grant[0]) begin g0 = c; req_valid[0] = 1'b0; end
      end
      check_eq("R6", "beats of 3-beat transfer", nb, 3);
      check_eq("R7", "waiting dst granted at G+2L+1", g5, 7);
      check_eq("R8", "round robin puts port 0 after 5", g0, 8);
      req_valid = '0;
      repeat (6) @(negedge clk);

      // R8: all ports request at once; last grant went to port 0
      for (int p = 0; p < N; p++) set_req(p, (p + 1) % N, 1);
      for (int i = 0; i < N; i++) begin
         @(negedge clk);
         check_eq("R8", $sformatf("rr grant %0d", i), int'(grant), 1 << ((1 + i) % N));
         check_eq("R3", "rr ring", int'(grant_ring), 0);
         req_valid[(1 + i) % N] = 1'b0;
      end
      repeat (4) @(negedge clk);
      check_eq("R7", "all released", int'(tx_beat | rx_valid | grant), 0);

      done = 1;
      report();
   end
endmodule